// File: doc/BRIEF.md
# Real-Time Clock Update Sequencer with Alarm

This block keeps a calendar clock in packed BCD, 24-hour form: seconds, minutes, hours, day of week, day of month, month, year and century. A free-running time base delivers one-cycle `tick` pulses. Each time `TICKS_PER_SEC` ticks have gone by, the internal time advances by one second. The update-in-progress flag `uip` then rises. After `UIP_TICKS` further ticks the visible time registers take the new value and `uip` drops. On that same edge, a one-cycle pulse on `flag_set` reports which status-register flags the update raises.

Software changes the time through a single-byte load port. While set mode is active, the visible registers stay frozen and no update cycle starts. The internal time keeps running in the meantime. If a field was written during set mode, the internal time is rebuilt from the visible registers when set mode ends. The divider control stops the clock and clears the sub-second count. Alarm bytes whose two top bits are both 1 act as wildcards.

Top module: `rtc_update_core`

## Requirements
- R1: After reset the visible time is 00:00:00, day of week 01, date 01/01, year 00, century 20; `uip` is 0 and `flag_set` is 0.
- R2: On the tick that completes a second (one every `TICKS_PER_SEC` ticks), `uip` rises on that clock edge. It stays high for `UIP_TICKS` ticks. The visible time takes the advanced value on the edge where `uip` falls.
- R3: The time advances in BCD: seconds 59 carry into minutes, minutes 59 into hours, hours 23 into the date; day of week runs 01..07 and wraps 07 to 01; month 12 wraps to 01 and carries the year; year 99 wraps to 00 and carries the century.
- R4: When `upd_ie` is 1 at the update edge, `flag_set` pulses for one cycle with bits 7 and 4 set (0x90); `flag_set` is nonzero only on the edge where `uip` falls.
- R5: When `alm_ie` is 1, the alarm matches if seconds, minutes and hours each equal their alarm byte, an alarm byte with bits 7 and 6 both 1 matching anything; a match adds bits 7 and 5 (0xA0) to the pulse, giving 0xB0 together with R4. Bits 6 and 3..0 of `flag_set` are never set.
- R6: Day of month wraps after 30 in months 04, 06, 09, 11, after 31 in the other months except 02. Month 02 wraps after 29 in a leap year and after 28 otherwise. A leap year is a nonzero year divisible by 4, or year 00 with a century divisible by 4.
- R7: While `div_ctl` is 2'b11 the clock is held: no second elapses, `uip` never rises and the sub-second count restarts, so the first second after release takes a full `TICKS_PER_SEC` ticks.
- R8: While `set_mode` is 1, `uip` does not rise and the visible time changes only through loads. A field loaded during set mode is copied into the internal time on the first edge with `set_mode` 0, and counting continues from it.
- R9: A load (`ld_en` 1) writes `ld_data` into the visible field chosen by `ld_sel` on the next edge; outside set mode it also writes the internal time. Codes: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 century (mirror location). Codes 9..15 change nothing.
- R10: The century appears on both `t_cent` and `t_cent_mirror` with equal value, whichever of the two century codes wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse |
| div_ctl | input | 2 | Divider control; 2'b11 holds the clock |
| set_mode | input | 1 | Freeze visible time, defer loads |
| upd_ie | input | 1 | Update-ended flag enable |
| alm_ie | input | 1 | Alarm flag enable |
| alm_sec | input | 8 | Alarm seconds, BCD or wildcard |
| alm_min | input | 8 | Alarm minutes, BCD or wildcard |
| alm_hour | input | 8 | Alarm hours, BCD or wildcard |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 4 | Field select for a load |
| ld_data | input | 8 | BCD value to load |
| t_sec | output | 8 | Visible seconds |
| t_min | output | 8 | Visible minutes |
| t_hour | output | 8 | Visible hours |
| t_wday | output | 8 | Visible day of week |
| t_mday | output | 8 | Visible day of month |
| t_mon | output | 8 | Visible month |
| t_year | output | 8 | Visible year |
| t_cent | output | 8 | Visible century |
| t_cent_mirror | output | 8 | Century, second location |
| uip | output | 1 | Update in progress |
| flag_set | output | 8 | One-cycle status flag set pulse |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 16 and `UIP_TICKS` = 8, and a tick arrives every fourth clock. With these values a second lasts 64 cycles and half of it lies inside the update window. Second, minute, hour, day, month, year and century carries can therefore be reached from loaded values within a few seconds each. Leap and non-leap February, the wildcard alarm, the divider hold and set mode with a deferred load can all be driven inside a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] minu;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [3:0] SEL_SEC         = 4'd0;
  localparam logic [3:0] SEL_MIN         = 4'd1;
  localparam logic [3:0] SEL_HOUR        = 4'd2;
  localparam logic [3:0] SEL_WDAY        = 4'd3;
  localparam logic [3:0] SEL_MDAY        = 4'd4;
  localparam logic [3:0] SEL_MON         = 4'd5;
  localparam logic [3:0] SEL_YEAR        = 4'd6;
  localparam logic [3:0] SEL_CENT        = 4'd7;
  localparam logic [3:0] SEL_CENT_MIRROR = 4'd8;

  localparam rtc_time_t RTC_RESET_TIME = '{cent: 8'h20, year: 8'h00, mon: 8'h01,
                                           mday: 8'h01, wday: 8'h01, hour: 8'h00,
                                           minu: 8'h00, sec: 8'h00};

  localparam logic [7:0] FLG_UPDATE = 8'h90;
  localparam logic [7:0] FLG_ALARM  = 8'hA0;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr, input logic [7:0] cen);
    logic [6:0] y;
    logic [6:0] c;
    y = bcd_to_bin(yr);
    c = bcd_to_bin(cen);
    if (y == 7'd0) return (c % 7'd4) == 7'd0;
    return (y % 7'd4) == 7'd0;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t r;
    r = t;
    if (t.sec != 8'h59) begin
      r.sec = bcd_inc(t.sec);
    end else begin
      r.sec = 8'h00;
      if (t.minu != 8'h59) begin
        r.minu = bcd_inc(t.minu);
      end else begin
        r.minu = 8'h00;
        if (t.hour != 8'h23) begin
          r.hour = bcd_inc(t.hour);
        end else begin
          r.hour = 8'h00;
          r.wday = (t.wday == 8'h07) ? 8'h01 : bcd_inc(t.wday);
          if (t.mday != month_last(t.mon, leap_year(t.year, t.cent))) begin
            r.mday = bcd_inc(t.mday);
          end else begin
            r.mday = 8'h01;
            if (t.mon != 8'h12) begin
              r.mon = bcd_inc(t.mon);
            end else begin
              r.mon = 8'h01;
              if (t.year != 8'h99) begin
                r.year = bcd_inc(t.year);
              end else begin
                r.year = 8'h00;
                r.cent = (t.cent == 8'h99) ? 8'h00 : bcd_inc(t.cent);
              end
            end
          end
        end
      end
    end
    return r;
  endfunction

  function automatic rtc_time_t put_field(input rtc_time_t t, input logic [3:0] sel,
                                          input logic [7:0] d);
    rtc_time_t r;
    r = t;
    case (sel)
      SEL_SEC:                   r.sec  = d;
      SEL_MIN:                   r.minu = d;
      SEL_HOUR:                  r.hour = d;
      SEL_WDAY:                  r.wday = d;
      SEL_MDAY:                  r.mday = d;
      SEL_MON:                   r.mon  = d;
      SEL_YEAR:                  r.year = d;
      SEL_CENT, SEL_CENT_MIRROR: r.cent = d;
      default:                   r      = t;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_tick_seq.sv
module rtc_tick_seq #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic set_mode,
  output logic sec_evt,
  output logic upd_evt,
  output logic uip
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam int UW = $clog2(UIP_TICKS + 1);

  logic [CW-1:0] sub_cnt;
  logic [UW-1:0] win_cnt;

  assign sec_evt = tick && !hold && (sub_cnt == CW'(TICKS_PER_SEC - 1));
  assign upd_evt = uip && tick && (win_cnt == UW'(UIP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt <= '0;
      win_cnt <= '0;
      uip     <= 1'b0;
    end else begin
      if (hold)         sub_cnt <= '0;
      else if (sec_evt) sub_cnt <= '0;
      else if (tick)    sub_cnt <= sub_cnt + 1'b1;

      if (upd_evt) begin
        uip <= 1'b0;
      end else if (sec_evt && !set_mode) begin
        uip     <= 1'b1;
        win_cnt <= '0;
      end else if (uip && tick) begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       restore,
  input  rtc_time_t  restore_val,
  output rtc_time_t  now
);
  rtc_time_t nxt;

  always_comb begin
    nxt = step ? advance(now) : now;
    if (wr_en) nxt = put_field(nxt, wr_sel, wr_data);
  end

  always_ff @(posedge clk) begin
    if (rst)          now <= RTC_RESET_TIME;
    else if (restore) now <= restore_val;
    else              now <= nxt;
  end
endmodule

// File: rtl/rtc_alarm_eval.sv
module rtc_alarm_eval
  import rtc_pkg::*;
(
  input  logic [2:0][7:0] cur_hms,
  input  logic [2:0][7:0] alm_hms,
  input  logic            upd_ie,
  input  logic            alm_ie,
  output logic [7:0]      flags
);
  logic [2:0] hit;

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    assign hit[i] = (alm_hms[i][7:6] == 2'b11) || (alm_hms[i] == cur_hms[i]);
  end

  always_comb begin
    flags = 8'h00;
    if (upd_ie)            flags = flags | FLG_UPDATE;
    if (alm_ie && (&hit))  flags = flags | FLG_ALARM;
  end
endmodule

// File: rtl/rtc_update_core.sv
module rtc_update_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] div_ctl,
  input  logic       set_mode,
  input  logic       upd_ie,
  input  logic       alm_ie,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic       ld_en,
  input  logic [3:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hour,
  output logic [7:0] t_wday,
  output logic [7:0] t_mday,
  output logic [7:0] t_mon,
  output logic [7:0] t_year,
  output logic [7:0] t_cent,
  output logic [7:0] t_cent_mirror,
  output logic       uip,
  output logic [7:0] flag_set
);
  logic      hold, sec_evt, upd_evt;
  logic      ld_ok, set_q, pend, restore, copy_en;
  rtc_time_t cur, vis, vis_nx;
  logic [7:0] flags_nx;

  assign hold    = &div_ctl;
  assign ld_ok   = ld_en && (ld_sel <= SEL_CENT_MIRROR);
  assign restore = set_q && !set_mode && pend;
  assign copy_en = upd_evt && !set_mode && !restore;

  rtc_tick_seq #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .hold(hold), .set_mode(set_mode),
    .sec_evt(sec_evt), .upd_evt(upd_evt), .uip(uip)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .step(sec_evt),
    .wr_en(ld_ok && !set_mode), .wr_sel(ld_sel), .wr_data(ld_data),
    .restore(restore), .restore_val(vis), .now(cur)
  );

  rtc_alarm_eval u_alm (
    .cur_hms({cur.hour, cur.minu, cur.sec}),
    .alm_hms({alm_hour, alm_min, alm_sec}),
    .upd_ie(upd_ie), .alm_ie(alm_ie), .flags(flags_nx)
  );

  always_comb begin
    vis_nx = copy_en ? cur : vis;
    if (ld_ok) vis_nx = put_field(vis_nx, ld_sel, ld_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis      <= RTC_RESET_TIME;
      flag_set <= 8'h00;
      set_q    <= 1'b0;
      pend     <= 1'b0;
    end else begin
      vis      <= vis_nx;
      flag_set <= copy_en ? flags_nx : 8'h00;
      set_q    <= set_mode;
      if (restore)                pend <= 1'b0;
      else if (ld_ok && set_mode) pend <= 1'b1;
    end
  end

  assign t_sec         = vis.sec;
  assign t_min         = vis.minu;
  assign t_hour        = vis.hour;
  assign t_wday        = vis.wday;
  assign t_mday        = vis.mday;
  assign t_mon         = vis.mon;
  assign t_year        = vis.year;
  assign t_cent        = vis.cent;
  assign t_cent_mirror = vis.cent;
endmodule

// File: rtl/rtc_update_core_chk.sv
module rtc_update_core_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] div_ctl,
  input logic       set_mode,
  input logic       upd_ie,
  input logic       ld_en,
  input logic       restore,
  input logic       uip,
  input logic [7:0] flag_set,
  input logic [7:0] t_sec,
  input logic [7:0] t_min,
  input logic [7:0] t_hour
);
  assert_flag_shape_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_set != 8'h00) |-> (flag_set[7] && !flag_set[6] && (flag_set[3:0] == 4'h0)));

  assert_flag_at_update_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_set != 8'h00) |-> (!uip && $past(uip)));

  assert_update_flag_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(uip) && $past(upd_ie) && !$past(set_mode) && !$past(restore))
      |-> (flag_set[7] && flag_set[4]));

  assert_hold_no_uip_R7: assert property (@(posedge clk) disable iff (rst)
    (&div_ctl) |=> !$rose(uip));

  assert_set_no_uip_R8: assert property (@(posedge clk) disable iff (rst)
    set_mode |=> !$rose(uip));

  assert_set_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(set_mode) && !$past(ld_en))
      |-> ($stable(t_sec) && $stable(t_min) && $stable(t_hour)));
endmodule

bind rtc_update_core rtc_update_core_chk u_chk (
  .clk(clk), .rst(rst), .div_ctl(div_ctl), .set_mode(set_mode), .upd_ie(upd_ie),
  .ld_en(ld_en), .restore(restore), .uip(uip), .flag_set(flag_set),
  .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour)
);

// File: tb/rtc_update_core_tb.sv
module rtc_update_core_tb;
  localparam int TPS = 16;
  localparam int UT  = 8;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [1:0] div_ctl = 2'b00;
  logic set_mode = 1'b0, upd_ie = 1'b0, alm_ie = 1'b0;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
  logic ld_en = 1'b0;
  logic [3:0] ld_sel = 4'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year, t_cent, t_cent_mirror;
  logic uip;
  logic [7:0] flag_set;

  int n_chk = 0, n_fail = 0, cyc = 0, uip_rises = 0;
  logic prev_uip = 1'b0;
  logic [7:0] last_flg;

  rtc_update_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UT)) u_dut (.*);

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tick = ((cyc % 4) == 3);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- reference model (binary fields, index 0 sec .. 7 century)
  int mi[8], mv[8];
  int tcnt, ucnt, pend, setq;
  logic muip;
  logic [7:0] mflg;

  function automatic int tobcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int frombcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(input int mo, input int yr, input int ce);
    bit lp;
    lp = (yr != 0) ? (yr % 4 == 0) : (ce % 4 == 0);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv(inout int a[8]);
    a[0]++;
    if (a[0] == 60) begin
      a[0] = 0; a[1]++;
      if (a[1] == 60) begin
        a[1] = 0; a[2]++;
        if (a[2] == 24) begin
          a[2] = 0;
          a[3] = (a[3] == 7) ? 1 : a[3] + 1;
          if (a[4] == mdays(a[5], a[6], a[7])) begin
            a[4] = 1;
            if (a[5] == 12) begin
              a[5] = 1;
              if (a[6] == 99) begin a[6] = 0; a[7] = (a[7] == 99) ? 0 : a[7] + 1; end
              else a[6]++;
            end else a[5]++;
          end else a[4]++;
        end
      end
    end
  endtask

  task automatic mput(inout int a[8], input logic [3:0] sel, input logic [7:0] d);
    if (sel == 4'd8) a[7] = frombcd(d);
    else if (sel <= 4'd7) a[sel] = frombcd(d);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mi = '{0, 0, 0, 1, 1, 1, 0, 20};
      mv = mi;
      tcnt = 0; ucnt = 0; muip = 1'b0; pend = 0; setq = 0; mflg = 8'h00;
    end else begin
      int o[8];
      bit hold, secev, updev, rest, ldv, cp, m;
      o = mi;
      hold  = (div_ctl == 2'b11);
      secev = tick && !hold && (tcnt == TPS - 1);
      updev = muip && tick && (ucnt == UT - 1);
      rest  = setq && !set_mode && pend;
      ldv   = ld_en && (ld_sel <= 4'd8);
      if (hold) tcnt = 0;
      else if (tick) tcnt = (tcnt == TPS - 1) ? 0 : tcnt + 1;
      if (updev) muip = 1'b0;
      else if (secev && !set_mode) begin muip = 1'b1; ucnt = 0; end
      else if (muip && tick) ucnt++;
      if (rest) mi = mv;
      else begin
        if (secev) adv(mi);
        if (ldv && !set_mode) mput(mi, ld_sel, ld_data);
      end
      cp = updev && !set_mode && !rest;
      mflg = 8'h00;
      if (cp) begin
        if (upd_ie) mflg = mflg | 8'h90;
        m = 1;
        if (!(alm_sec[7:6] == 2'b11 || alm_sec == 8'(tobcd(o[0])))) m = 0;
        if (!(alm_min[7:6] == 2'b11 || alm_min == 8'(tobcd(o[1])))) m = 0;
        if (!(alm_hour[7:6] == 2'b11 || alm_hour == 8'(tobcd(o[2])))) m = 0;
        if (alm_ie && m) mflg = mflg | 8'hA0;
        mv = o;
      end
      if (ldv) mput(mv, ld_sel, ld_data);
      if (rest) pend = 0;
      else if (ldv && set_mode) pend = 1;
      setq = set_mode;
    end
  end

  // every-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && cyc > 2) begin
      chk("R3 sec",   t_sec,  8'(tobcd(mv[0])));
      chk("R3 min",   t_min,  8'(tobcd(mv[1])));
      chk("R3 hour",  t_hour, 8'(tobcd(mv[2])));
      chk("R3 wday",  t_wday, 8'(tobcd(mv[3])));
      chk("R6 mday",  t_mday, 8'(tobcd(mv[4])));
      chk("R6 mon",   t_mon,  8'(tobcd(mv[5])));
      chk("R3 year",  t_year, 8'(tobcd(mv[6])));
      chk("R10 cent", t_cent, 8'(tobcd(mv[7])));
      chk("R10 mirror", t_cent_mirror, 8'(tobcd(mv[7])));
      chk("R2 uip",   {7'd0, uip}, {7'd0, muip});
      chk("R4 R5 flags", flag_set, mflg);
    end
    if (uip && !prev_uip) uip_rises++;
    prev_uip = uip;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  task automatic load(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_update();
    do @(negedge clk); while (uip !== 1'b1);
    do @(negedge clk); while (uip !== 1'b0);
    last_flg = flag_set;
  endtask

  initial begin
    logic [7:0] s0, m0, h0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sec", t_sec, 8'h00);   chk("R1 min", t_min, 8'h00);
    chk("R1 hour", t_hour, 8'h00); chk("R1 wday", t_wday, 8'h01);
    chk("R1 mday", t_mday, 8'h01); chk("R1 mon", t_mon, 8'h01);
    chk("R1 cent", t_cent, 8'h20); chk("R1 uip", {7'd0, uip}, 8'h00);
    chk("R1 flags", flag_set, 8'h00);
    rst = 1'b0;

    // R2 / R4 first second
    upd_ie = 1'b1;
    wait_update();
    chk("R2 first second", t_sec, 8'h01);
    chk("R4 update flags", last_flg, 8'h90);

    // R3 / R6 / R10 leap February in year 2000
    load(4'd0, 8'h58); load(4'd1, 8'h59); load(4'd2, 8'h23); load(4'd3, 8'h07);
    load(4'd4, 8'h28); load(4'd5, 8'h02); load(4'd6, 8'h00); load(4'd8, 8'h20);
    chk("R9 load visible", t_hour, 8'h23);
    chk("R10 cent via mirror code", t_cent, 8'h20);
    wait_update();
    chk("R3 sec 59", t_sec, 8'h59);
    wait_update();
    chk("R3 hour wrap", t_hour, 8'h00);
    chk("R3 wday wrap", t_wday, 8'h01);
    chk("R6 leap day", t_mday, 8'h29);
    chk("R6 leap month", t_mon, 8'h02);

    // R6 non-leap 1900
    wait_update();
    load(4'd0, 8'h59); load(4'd1, 8'h59); load(4'd2, 8'h23);
    load(4'd4, 8'h28); load(4'd5, 8'h02); load(4'd6, 8'h00); load(4'd7, 8'h19);
    chk("R10 mirror via cent code", t_cent_mirror, 8'h19);
    wait_update();
    chk("R6 non-leap mday", t_mday, 8'h01);
    chk("R6 non-leap mon", t_mon, 8'h03);

    // R3 year and century carry
    wait_update();
    load(4'd0, 8'h59); load(4'd1, 8'h59); load(4'd2, 8'h23); load(4'd3, 8'h03);
    load(4'd4, 8'h31); load(4'd5, 8'h12); load(4'd6, 8'h99); load(4'd7, 8'h19);
    wait_update();
    chk("R3 year wrap", t_year, 8'h00);
    chk("R3 century carry", t_cent, 8'h20);
    chk("R3 month wrap", t_mon, 8'h01);
    chk("R3 wday step", t_wday, 8'h04);

    // R5 alarm with wildcard minutes
    upd_ie = 1'b0; alm_ie = 1'b1;
    alm_hour = 8'h10; alm_min = 8'hC5; alm_sec = 8'h06;
    wait_update();
    load(4'd2, 8'h10); load(4'd1, 8'h20); load(4'd0, 8'h05);
    wait_update();
    chk("R5 alarm match", last_flg, 8'hA0);
    wait_update();
    chk("R5 alarm miss", last_flg, 8'h00);
    upd_ie = 1'b1; alm_sec = 8'hC0;
    wait_update();
    chk("R5 alarm and update", last_flg, 8'hB0);
    alm_hour = 8'h11;
    wait_update();
    chk("R5 hour mismatch", last_flg, 8'h90);

    // R9 ignored select code
    wait_update();
    s0 = t_sec; m0 = t_min; h0 = t_hour;
    load(4'd9, 8'h33);
    chk("R9 ignored sec", t_sec, s0);
    chk("R9 ignored min", t_min, m0);
    chk("R9 ignored hour", t_hour, h0);

    // R7 divider hold
    wait_update();
    div_ctl = 2'b11;
    s0 = t_sec;
    uip_rises = 0;
    repeat (200) @(negedge clk);
    chk("R7 no uip in hold", 8'(uip_rises), 8'h00);
    chk("R7 time held", t_sec, s0);
    div_ctl = 2'b00;
    wait_update();
    chk("R7 resumes", t_sec, 8'(tobcd(frombcd(s0) + 1)));

    // R8 set mode with deferred load
    set_mode = 1'b1;
    s0 = t_sec;
    uip_rises = 0;
    repeat (150) @(negedge clk);
    chk("R8 frozen", t_sec, s0);
    chk("R8 no uip", 8'(uip_rises), 8'h00);
    load(4'd0, 8'h30);
    chk("R8 load visible", t_sec, 8'h30);
    set_mode = 1'b0;
    wait_update();
    chk("R8 resume from load", t_sec, 8'h31);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule